// File: doc/BRIEF.md
# Display Controller Register Window with Vertical-Sync Interrupt

This block is the upper half of a display controller's 32-byte register space. It decodes byte offsets 0x10 through 0x1F. Offset 0x10 holds a control byte, and bit 7 of that byte enables the interrupt. Offset 0x11 is a status byte. It reports whether an interrupt is pending and always shows a fixed board-identity pattern. Offsets 0x12 through 0x1F are plain byte registers that software uses for cursor and timing settings. Offsets below 0x10 belong to other logic, so this block reads them as zero and ignores writes to them.

A one-cycle vertical-sync pulse from the video timing logic latches an interrupt request, but only while interrupts are enabled. The interrupt output is a level. It stays high until software writes any value to the status offset. Reads have no side effects and return data in the same cycle as the address.

Top module: `dispctl_regs`

## Requirements
- R1: Offset 0x10 is a full 8-bit read/write control register, and its bit 7 is the interrupt enable.
- R2: A read of offset 0x11 returns the pending flag in bit 7, with bits 6, 5 and 0 always set to one (0x61 ORed in) and every other bit zero.
- R3: A vsync pulse seen while control bit 7 is one sets the pending flag at the next clock edge. The flag then holds, and `irq_o` equals it.
- R4: A vsync pulse seen while control bit 7 is zero leaves the pending flag and `irq_o` unchanged.
- R5: A write of any data value to offset 0x11 clears the pending flag at the next clock edge. The written value is otherwise discarded.
- R6: When a vsync pulse with interrupts enabled and a write to 0x11 fall in the same cycle, the flag ends up set.
- R7: Offsets 0x12 to 0x1F are 14 independent 8-bit read/write registers. A write to one of them leaves the others unchanged.
- R8: Offsets 0x00 to 0x0F read as zero, and writes to them change no register.
- R9: Reset drives `irq_o` low and clears the control register, the pending flag and all byte registers.
- R10: `rdata_o` follows `addr_i` combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the byte at `addr_i` |
| addr_i | input | 5 | Byte offset in the 32-byte region |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| vsync_i | input | 1 | One-cycle vertical-sync pulse |
| irq_o | output | 1 | Level interrupt, equal to the pending flag |

## Verification
The bench aims at the points where a plausible design goes wrong.

- **Clear with a data mask.** The bench writes 0x00 to the status byte. A design that used the written data as a mask, instead of clearing on any write, would leave the interrupt asserted.
- **Set against clear in one cycle.** The bench lands a vsync pulse and a status write in the same cycle. A design that let the clear win would drop an interrupt.
- **Enable bit versus neighbouring bits.** A vsync pulse arrives with every control bit set except bit 7. A design that tested the wrong bit would raise the interrupt.
- **Window decode.** Writes go to an offset below the window and to its last byte, then other registers are read back. A design that ignored the window edges would alias those writes into the control or byte registers.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    // Bit positions used by both the decoder users and the checker logic.
    localparam int IRQ_EN_BIT = 7;
    localparam int PEND_BIT   = 7;

    // Bits forced to one on every status read: sense code 0x60, colour id 0x01.
    localparam logic [7:0] STAT_FIXED = 8'h61;

    // Word slots inside the window.
    localparam int SLOT_CTRL  = 0;
    localparam int SLOT_STAT  = 1;
    localparam int SLOT_FIRST = 2;

    typedef struct packed {
        logic hit;
        logic is_ctrl;
        logic is_stat;
        logic is_byte;
    } dec_t;

endpackage

// File: rtl/dcr_decode.sv
module dcr_decode
    import dcr_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int WIN_BASE = 16,
    parameter int WIN_REGS = 16,
    localparam int IDX_W   = $clog2(WIN_REGS)
) (
    input  logic [ADDR_W-1:0] addr_i,
    output dec_t              dec_o,
    output logic [IDX_W-1:0]  idx_o
);

    logic [ADDR_W:0] rel;

    always_comb begin
        rel          = {1'b0, addr_i} - (ADDR_W+1)'(WIN_BASE);
        dec_o        = '0;
        idx_o        = rel[IDX_W-1:0];
        dec_o.hit    = (int'(addr_i) >= WIN_BASE) && (int'(addr_i) < WIN_BASE + WIN_REGS);
        if (dec_o.hit) begin
            dec_o.is_ctrl = (int'(idx_o) == SLOT_CTRL);
            dec_o.is_stat = (int'(idx_o) == SLOT_STAT);
            dec_o.is_byte = (int'(idx_o) >= SLOT_FIRST);
        end
    end

endmodule

// File: rtl/dcr_irq.sv
module dcr_irq
    import dcr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we_i,
    input  logic              stat_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              vsync_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic              pend_o
);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic              pend;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic    fire;

    always_comb begin
        st_d = st_q;
        fire = vsync_i && st_q.ctrl[IRQ_EN_BIT];
        if (ctrl_we_i) st_d.ctrl = wdata_i;
        // set beats clear when both land together
        if (fire)           st_d.pend = 1'b1;
        else if (stat_we_i) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign pend_o = st_q.pend;

    // R3 R6
    vsync_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_i && ctrl_o[IRQ_EN_BIT]) |=> pend_o);

    // R5
    wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we_i && !(vsync_i && ctrl_o[IRQ_EN_BIT])) |=> !pend_o);

    // R4
    pend_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_we_i && !(vsync_i && ctrl_o[IRQ_EN_BIT])) |=> $stable(pend_o));

endmodule

// File: rtl/dcr_bytes.sv
module dcr_bytes #(
    parameter int DATA_W   = 8,
    parameter int NREGS    = 16,
    parameter int FIRST    = 2,
    localparam int IDX_W   = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] rd_arr [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_slot
        if (g < FIRST) begin : g_none
            assign rd_arr[g] = '0;
        end else begin : g_reg
            logic [DATA_W-1:0] byte_d, byte_q;

            always_comb begin
                byte_d = byte_q;
                if (we_i && (int'(idx_i) == g)) byte_d = wdata_i;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) byte_q <= '0;
                else        byte_q <= byte_d;
            end

            assign rd_arr[g] = byte_q;

            // R7
            write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (we_i && (int'(idx_i) == g)) |=> (byte_q == $past(wdata_i)));
        end
    end

    assign rdata_o = rd_arr[idx_i];

endmodule

// File: rtl/dispctl_regs.sv
module dispctl_regs
    import dcr_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 8,
    parameter int WIN_BASE = 16,
    parameter int WIN_REGS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              vsync_i,
    output logic              irq_o
);

    localparam int IDX_W = $clog2(WIN_REGS);

    dec_t              dec;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] ctrl_q, bytes_rd, stat_rd;
    logic              pend_q;

    dcr_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_REGS(WIN_REGS)) u_dec (
        .addr_i (addr_i),
        .dec_o  (dec),
        .idx_o  (idx)
    );

    dcr_irq #(.DATA_W(DATA_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we_i (wr_en_i && dec.is_ctrl),
        .stat_we_i (wr_en_i && dec.is_stat),
        .wdata_i   (wdata_i),
        .vsync_i   (vsync_i),
        .ctrl_o    (ctrl_q),
        .pend_o    (pend_q)
    );

    dcr_bytes #(.DATA_W(DATA_W), .NREGS(WIN_REGS), .FIRST(SLOT_FIRST)) u_bytes (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en_i && dec.is_byte),
        .idx_i   (idx),
        .wdata_i (wdata_i),
        .rdata_o (bytes_rd)
    );

    always_comb begin
        stat_rd           = DATA_W'(STAT_FIXED);
        stat_rd[PEND_BIT] = pend_q;
        rdata_o           = '0;
        if (dec.is_ctrl)      rdata_o = ctrl_q;
        else if (dec.is_stat) rdata_o = stat_rd;
        else if (dec.is_byte) rdata_o = bytes_rd;
    end

    assign irq_o = pend_q;

    // R2
    stat_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_W'(WIN_BASE + SLOT_STAT)) |-> (rdata_o[PEND_BIT] == irq_o));

    // R8
    below_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr_i) < WIN_BASE) |-> (rdata_o == '0));

    // R1
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(WIN_BASE + SLOT_CTRL)) |=> (ctrl_q == $past(wdata_i)));

endmodule

// File: tb/sim_dispctl_regs.sv
`timescale 1ns/1ps
module sim_dispctl_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       vsync = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dispctl_regs u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .vsync_i (vsync),
        .irq_o   (irq)
    );

    // fields: req[32:29] wr[28] addr[27:23] wdata[22:15] vs[14] raddr[13:9] exp[8:1] irq[0]
    localparam int NV = 18;
    localparam logic [32:0] VEC [NV] = '{
        {4'd1,  1'b1, 5'h10, 8'h80, 1'b0, 5'h10, 8'h80, 1'b0}, // R1 enable
        {4'd3,  1'b0, 5'h00, 8'h00, 1'b1, 5'h11, 8'hE1, 1'b1}, // R3 set
        {4'd5,  1'b1, 5'h11, 8'h00, 1'b0, 5'h11, 8'h61, 1'b0}, // R5 zero data clears
        {4'd1,  1'b1, 5'h10, 8'h00, 1'b0, 5'h10, 8'h00, 1'b0}, // R1 disable
        {4'd4,  1'b0, 5'h00, 8'h00, 1'b1, 5'h11, 8'h61, 1'b0}, // R4 masked
        {4'd7,  1'b1, 5'h12, 8'hA5, 1'b0, 5'h12, 8'hA5, 1'b0}, // R7 first byte
        {4'd7,  1'b1, 5'h1F, 8'h3C, 1'b0, 5'h1F, 8'h3C, 1'b0}, // R7 last byte
        {4'd7,  1'b0, 5'h00, 8'h00, 1'b0, 5'h12, 8'hA5, 1'b0}, // R7 independence
        {4'd8,  1'b1, 5'h05, 8'hFF, 1'b0, 5'h05, 8'h00, 1'b0}, // R8 below window
        {4'd8,  1'b0, 5'h00, 8'h00, 1'b0, 5'h10, 8'h00, 1'b0}, // R8 no alias into ctrl
        {4'd1,  1'b1, 5'h10, 8'h7F, 1'b0, 5'h10, 8'h7F, 1'b0}, // R1 all low bits
        {4'd4,  1'b0, 5'h00, 8'h00, 1'b1, 5'h11, 8'h61, 1'b0}, // R4 only bit 7 enables
        {4'd1,  1'b1, 5'h10, 8'hFF, 1'b0, 5'h10, 8'hFF, 1'b0}, // R1
        {4'd3,  1'b0, 5'h00, 8'h00, 1'b1, 5'h11, 8'hE1, 1'b1}, // R3 set
        {4'd3,  1'b0, 5'h00, 8'h00, 1'b0, 5'h11, 8'hE1, 1'b1}, // R3 holds
        {4'd6,  1'b1, 5'h11, 8'h00, 1'b1, 5'h11, 8'hE1, 1'b1}, // R6 set wins
        {4'd5,  1'b1, 5'h11, 8'h5A, 1'b0, 5'h11, 8'h61, 1'b0}, // R5 any data
        {4'd2,  1'b1, 5'h11, 8'hFF, 1'b0, 5'h11, 8'h61, 1'b0}  // R2 fixed bits only
    };

    task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        #12;
        @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        addr = 5'h10; #1; chk(9, rdata, 8'h00);
        addr = 5'h11; #1; chk(9, rdata, 8'h61);
        addr = 5'h1F; #1; chk(9, rdata, 8'h00);
        chk(9, {7'd0, irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [32:0] v;
            v = VEC[i];
            @(negedge clk);
            wr_en = v[28]; addr = v[27:23]; wdata = v[22:15]; vsync = v[14];
            @(negedge clk);
            wr_en = 1'b0; vsync = 1'b0; addr = v[13:9];
            #1;
            chk(int'(v[32:29]), rdata, v[8:1]);
            chk(int'(v[32:29]), {7'd0, irq}, {7'd0, v[0]});
        end

        // R10 read follows address without an edge
        @(negedge clk);
        addr = 5'h12; #1; chk(10, rdata, 8'hA5);
        addr = 5'h1F; #1; chk(10, rdata, 8'h3C);

        // R9 reset while pending
        @(negedge clk); vsync = 1'b1;
        @(negedge clk); vsync = 1'b0;
        chk(3, {7'd0, irq}, 8'h01);
        rst_n = 1'b0; #1;
        chk(9, {7'd0, irq}, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        addr = 5'h10; #1; chk(9, rdata, 8'h00);
        addr = 5'h12; #1; chk(9, rdata, 8'h00);
        addr = 5'h11; #1; chk(9, rdata, 8'h61);

        finish_run();
    end

endmodule